// File: doc/BRIEF.md
# Timer Output Waveform Action Unit

This block turns timer events into two output levels, a primary waveform line and a secondary waveform line. Five single-cycle strobes arrive from the surrounding timer: a software trigger, an external event, a compare hit on the primary threshold, a compare hit on the secondary threshold and a compare hit on the period threshold. Each output has its own 2-bit action code per event, so an event can leave an output alone, drive it high, drive it low or invert it. When events coincide in one cycle, a fixed priority picks the single action that applies.

A 2-bit source-select field says where the external event comes from. Code 0 means the secondary line itself is the event input. In that case the secondary line stops generating a waveform, its output enable drops, and its compare hits no longer raise the compare flag. Code 1, 2 and 3 select one of three auxiliary lines. In every case the external event still acts on the outputs. A sticky compare flag records compare hits and is cleared by a read strobe. Counting and clock generation belong to the surrounding timer and are not part of this block.

Each output line is a two-state machine with the states `LVL_LOW` and `LVL_HIGH`. The transitions are: `GO_HIGH` (set or invert from low), `GO_LOW` (clear or invert from high) and `STAY` (no action, an action that matches the current level, or hold).

Top module: `tmr_wave_action`

## Requirements
- R1: After reset, `tioa`, `tiob` and `cmp_flag` are all 0.
- R2: The action codes are 0 = none, 1 = set, 2 = clear, 3 = toggle. The chosen action changes the output on the first clock edge after the strobe cycle.
- R3: `tioa` responds to `sw_trig`, `ext_evt`, `rc_hit` and `ra_hit` through `a_sw_act`, `a_ext_act`, `a_rc_act` and `a_ra_act`. `tiob` responds to `sw_trig`, `ext_evt`, `rc_hit` and `rb_hit` through `b_sw_act`, `b_ext_act`, `b_rc_act` and `b_rb_act`.
- R4: For each output, coinciding events are resolved in this order: software trigger first, then external event, then the period compare, then the primary compare (for `tioa`) or the secondary compare (for `tiob`). An event whose action code is 0 does not block a lower-priority event.
- R5: When `ext_src_sel` is 0, `tiob_oe` is 0 and `tiob` holds its level whatever events occur. For codes 1 to 3, `tiob_oe` is 1.
- R6: `ext_evt` applies its action to `tioa` for every value of `ext_src_sel`, including 0.
- R7: `cmp_flag` becomes 1 on the edge after `ra_hit` or `rc_hit`, or after `rb_hit` while `tiob_oe` is 1.
- R8: `cmp_flag` returns to 0 on the edge after a `flag_rd` strobe. If a compare sets the flag in the same cycle, the set wins.
- R9: While `ext_src_sel` is 0, `rb_hit` alone does not set `cmp_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_trig | input | 1 | Software trigger strobe |
| ext_evt | input | 1 | External event strobe, already taken from the selected source |
| ra_hit | input | 1 | Primary compare strobe |
| rb_hit | input | 1 | Secondary compare strobe |
| rc_hit | input | 1 | Period compare strobe |
| a_sw_act | input | 2 | Action of the software trigger on `tioa` |
| a_ext_act | input | 2 | Action of the external event on `tioa` |
| a_rc_act | input | 2 | Action of the period compare on `tioa` |
| a_ra_act | input | 2 | Action of the primary compare on `tioa` |
| b_sw_act | input | 2 | Action of the software trigger on `tiob` |
| b_ext_act | input | 2 | Action of the external event on `tiob` |
| b_rc_act | input | 2 | Action of the period compare on `tiob` |
| b_rb_act | input | 2 | Action of the secondary compare on `tiob` |
| ext_src_sel | input | 2 | External event source: 0 = secondary line as input, 1 to 3 = auxiliary lines |
| flag_rd | input | 1 | Read strobe that clears `cmp_flag` |
| tioa | output | 1 | Primary waveform level |
| tiob | output | 1 | Secondary waveform level |
| tiob_oe | output | 1 | Output enable for the secondary line |
| cmp_flag | output | 1 | Sticky compare flag |

## Verification
The bench drives directed cases where strobes coincide, and it includes cases where the higher-priority event has action 0. A resolver that lets a "none" action block a lower event, or that inverts the priority order, leaves the output at the wrong level in those cycles. Other cases switch the source select to 0 in the middle of a waveform. A design that keeps the secondary line running, or that lets its compare raise the flag, shows a changed `tiob` or a set `cmp_flag`. A read that coincides with a compare catches a flag whose clear wins over its set. A long random run with mixed action codes then checks all outputs against a behavioural model on every clock.

// File: rtl/tmr_wave_pkg.sv
package tmr_wave_pkg;
    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2,
        ACT_TGL  = 2'd3
    } act_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;

    localparam int unsigned N_SRC = 4;  // index 0 has the highest priority
endpackage

// File: rtl/wave_pick.sv
module wave_pick
    import tmr_wave_pkg::*;
(
    input  logic [N_SRC-1:0] hit,
    input  act_e             acts [0:N_SRC-1],
    output act_e             win
);
    // Scan from the lowest priority upward; the last match is the highest-priority event (R4).
    always_comb begin
        win = ACT_NONE;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (hit[i] && acts[i] != ACT_NONE) win = acts[i];
        end
    end
endmodule

// File: rtl/wave_lvl.sv
module wave_lvl
    import tmr_wave_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  act_e win,
    output logic lvl
);
    lvl_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LVL_LOW;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (!hold) begin
            unique case (state)
                LVL_LOW:  if (win == ACT_SET || win == ACT_TGL) state_nx = LVL_HIGH; // GO_HIGH
                LVL_HIGH: if (win == ACT_CLR || win == ACT_TGL) state_nx = LVL_LOW;  // GO_LOW
                default:  state_nx = LVL_LOW;
            endcase
        end
    end

    always_comb lvl = (state == LVL_HIGH);

    assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && win == ACT_SET) |=> lvl);
    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && win == ACT_CLR) |=> !lvl);
    assert_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && win == ACT_TGL) |=> lvl != $past(lvl));
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(lvl));
endmodule

// File: rtl/cmp_flag_reg.sv
module cmp_flag_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic rd,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_req) flag <= 1'b1;
        else if (rd)      flag <= 1'b0;
    end

    assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> flag);
    assert_flag_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !set_req) |=> !flag);
endmodule

// File: rtl/tmr_wave_action.sv
module tmr_wave_action
    import tmr_wave_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_trig,
    input  logic       ext_evt,
    input  logic       ra_hit,
    input  logic       rb_hit,
    input  logic       rc_hit,
    input  logic [1:0] a_sw_act,
    input  logic [1:0] a_ext_act,
    input  logic [1:0] a_rc_act,
    input  logic [1:0] a_ra_act,
    input  logic [1:0] b_sw_act,
    input  logic [1:0] b_ext_act,
    input  logic [1:0] b_rc_act,
    input  logic [1:0] b_rb_act,
    input  logic [1:0] ext_src_sel,
    input  logic       flag_rd,
    output logic       tioa,
    output logic       tiob,
    output logic       tiob_oe,
    output logic       cmp_flag
);
    localparam logic [1:0] SEL_SELF = 2'd0;  // secondary line is the event input

    logic b_is_input;
    always_comb b_is_input = (ext_src_sel == SEL_SELF);
    always_comb tiob_oe    = !b_is_input;

    logic [N_SRC-1:0] hit_a, hit_b;
    act_e acts_a [0:N_SRC-1];
    act_e acts_b [0:N_SRC-1];
    act_e win_a, win_b;

    // Priority order per R3/R4: software, external, period compare, own compare.
    always_comb begin
        hit_a = {ra_hit, rc_hit, ext_evt, sw_trig};
        hit_b = {rb_hit, rc_hit, ext_evt, sw_trig};
        acts_a[0] = act_e'(a_sw_act);
        acts_a[1] = act_e'(a_ext_act);
        acts_a[2] = act_e'(a_rc_act);
        acts_a[3] = act_e'(a_ra_act);
        acts_b[0] = act_e'(b_sw_act);
        acts_b[1] = act_e'(b_ext_act);
        acts_b[2] = act_e'(b_rc_act);
        acts_b[3] = act_e'(b_rb_act);
    end

    wave_pick u_pick_a (.hit(hit_a), .acts(acts_a), .win(win_a));
    wave_pick u_pick_b (.hit(hit_b), .acts(acts_b), .win(win_b));

    wave_lvl u_lvl_a (.clk(clk), .rst_n(rst_n), .hold(1'b0),       .win(win_a), .lvl(tioa));
    wave_lvl u_lvl_b (.clk(clk), .rst_n(rst_n), .hold(b_is_input), .win(win_b), .lvl(tiob));

    logic flag_set;
    always_comb flag_set = ra_hit || rc_hit || (rb_hit && !b_is_input);

    cmp_flag_reg u_flag (.clk(clk), .rst_n(rst_n), .set_req(flag_set), .rd(flag_rd), .flag(cmp_flag));

    assert_b_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_src_sel == SEL_SELF) |=> $stable(tiob));
    assert_rb_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_src_sel == SEL_SELF && rb_hit && !ra_hit && !rc_hit && !cmp_flag) |=> !cmp_flag);
endmodule

// File: tb/test_tmr_wave_action.sv
module test_tmr_wave_action;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_trig = 0, ext_evt = 0, ra_hit = 0, rb_hit = 0, rc_hit = 0, flag_rd = 0;
    logic [1:0] a_sw_act = 0, a_ext_act = 0, a_rc_act = 0, a_ra_act = 0;
    logic [1:0] b_sw_act = 0, b_ext_act = 0, b_rc_act = 0, b_rb_act = 0;
    logic [1:0] ext_src_sel = 2'd1;
    logic tioa, tiob, tiob_oe, cmp_flag;

    int n_vec = 0;
    int n_bad = 0;
    int m_a = 0, m_b = 0, m_f = 0;

    always #4 clk = ~clk;  // 125 MHz

    tmr_wave_action i_tmr_wave_action (
        .clk(clk), .rst_n(rst_n), .sw_trig(sw_trig), .ext_evt(ext_evt),
        .ra_hit(ra_hit), .rb_hit(rb_hit), .rc_hit(rc_hit),
        .a_sw_act(a_sw_act), .a_ext_act(a_ext_act), .a_rc_act(a_rc_act), .a_ra_act(a_ra_act),
        .b_sw_act(b_sw_act), .b_ext_act(b_ext_act), .b_rc_act(b_rc_act), .b_rb_act(b_rb_act),
        .ext_src_sel(ext_src_sel), .flag_rd(flag_rd),
        .tioa(tioa), .tiob(tiob), .tiob_oe(tiob_oe), .cmp_flag(cmp_flag)
    );

    function automatic int apply_code(int cur, int code);
        if (code == 1) return 1;
        if (code == 2) return 0;
        if (code == 3) return 1 - cur;
        return cur;
    endfunction

    function automatic int first_code(bit e0, int c0, bit e1, int c1, bit e2, int c2, bit e3, int c3);
        if (e0 && c0 != 0) return c0;
        if (e1 && c1 != 0) return c1;
        if (e2 && c2 != 0) return c2;
        if (e3 && c3 != 0) return c3;
        return 0;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Called at a negedge: drive strobes, predict, advance one edge, compare.
    task automatic step(bit sw, bit ex, bit ra, bit rb, bit rc, bit rd);
        sw_trig = sw; ext_evt = ex; ra_hit = ra; rb_hit = rb; rc_hit = rc; flag_rd = rd;
        #1;
        check("R5 tiob_oe", int'(tiob_oe), (ext_src_sel != 0) ? 1 : 0);
        m_a = apply_code(m_a, first_code(sw, a_sw_act, ex, a_ext_act, rc, a_rc_act, ra, a_ra_act));
        if (ext_src_sel != 0)
            m_b = apply_code(m_b, first_code(sw, b_sw_act, ex, b_ext_act, rc, b_rc_act, rb, b_rb_act));
        if (ra || rc || (rb && ext_src_sel != 0)) m_f = 1;
        else if (rd) m_f = 0;
        @(negedge clk);
        check("R2/R3/R4/R6 tioa", int'(tioa), m_a);
        check("R2/R3/R4/R5 tiob", int'(tiob), m_b);
        check("R7/R8/R9 cmp_flag", int'(cmp_flag), m_f);
        sw_trig = 0; ext_evt = 0; ra_hit = 0; rb_hit = 0; rc_hit = 0; flag_rd = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 tioa", int'(tioa), 0);
        check("R1 tiob", int'(tiob), 0);
        check("R1 cmp_flag", int'(cmp_flag), 0);

        // R2 each code on tioa via the primary compare
        a_ra_act = 2'd1; step(0,0,1,0,0,0);
        a_ra_act = 2'd3; step(0,0,1,0,0,0);
        a_ra_act = 2'd3; step(0,0,1,0,0,0);
        a_ra_act = 2'd2; step(0,0,1,0,0,0);
        a_ra_act = 2'd0; step(0,0,1,0,0,1);
        // R3 secondary compare drives tiob only
        b_rb_act = 2'd1; step(0,0,0,1,0,0);
        // R4 software set beats period clear
        a_sw_act = 2'd1; a_rc_act = 2'd2; b_sw_act = 2'd2; b_rc_act = 2'd1;
        step(1,0,0,0,1,0);
        // R4 none on higher priority does not block lower
        a_sw_act = 2'd0; a_ext_act = 2'd0; a_rc_act = 2'd3;
        step(1,1,0,0,1,0);
        // R4 external beats period and own compare
        a_ext_act = 2'd2; a_rc_act = 2'd1; a_ra_act = 2'd1; b_ext_act = 2'd1; b_rb_act = 2'd2;
        step(0,1,1,1,1,0);
        // R8 read clears; read plus compare keeps flag
        step(0,0,0,0,0,1);
        step(0,0,1,0,0,1);
        step(0,0,0,0,0,1);
        // R5/R6/R9 secondary line as event input
        ext_src_sel = 2'd0;
        b_sw_act = 2'd3; b_ext_act = 2'd3; b_rb_act = 2'd3; a_ext_act = 2'd3;
        step(1,1,0,1,0,0);
        step(0,0,0,1,0,0);  // R9 rb alone must not set the flag
        step(0,1,0,0,0,0);  // R6 external still acts on tioa
        ext_src_sel = 2'd2;
        step(0,0,0,1,0,0);

        // random phase
        for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(0, 15) == 0) ext_src_sel = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 7) == 0) begin
                a_sw_act = 2'($urandom); a_ext_act = 2'($urandom);
                a_rc_act = 2'($urandom); a_ra_act = 2'($urandom);
                b_sw_act = 2'($urandom); b_ext_act = 2'($urandom);
                b_rc_act = 2'($urandom); b_rb_act = 2'($urandom);
            end
            step($urandom_range(0,3) == 0, $urandom_range(0,3) == 0, $urandom_range(0,3) == 0,
                 $urandom_range(0,3) == 0, $urandom_range(0,3) == 0, $urandom_range(0,2) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule